// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block reads one sample from an 8-bit serial analog-to-digital converter over a receive-only SPI link. The block is the master. When the system side raises a request, the block lowers an active-low chip select. It then generates a fixed number of serial clock cycles from the system clock, using an internal half-period counter. It collects the converter's reply on a single MISO line. A conversion frame starts with three pad bits. The eight sample bits follow, most significant first, and trailing pad bits fill the rest of the frame.

MISO crosses into the system clock domain through a flip-flop synchronizer. The capture strobe is delayed by the synchronizer's latency, so the byte reflects the line level present at each serial clock rising edge. One cycle after the last sample bit has been shifted in, the byte appears on the data output together with a single-cycle valid strobe. After the final rising edge of the frame, the serial clock and chip select both return high, and the block waits for the next request. There is no MOSI line and no device configuration.

Top module: `adc_spi_reader`

## Requirements
- R1: While rst_ni is low, the outputs are cs_no=1, sclk_o=1, valid_o=0 and data_o=0. This takes effect at once, including in the middle of a transfer.
- R2: Whenever cs_no is high, sclk_o is high. Between transfers both lines stay high.
- R3: If req_i is high while the block is idle, cs_no is low after the next clock edge.
- R4: During a transfer, every sclk_o level lasts HALF_CNT system clocks. HALF_CNT is CLK_HZ/(2*SCLK_HZ) rounded down, with a minimum of 1, which gives 12 at the defaults. This includes the first high phase after cs_no falls.
- R5: A transfer has exactly FRAME_BITS (16) sclk_o rising edges. cs_no rises one clock after the last rising edge, and sclk_o stays high.
- R6: The byte is made of the MISO levels at rising edges LEAD_BITS+1 through LEAD_BITS+DATA_BITS, which are edges 4 to 11 at the defaults. The first of these edges goes to data_o[7]. MISO levels at rising edges 1-3 and 12-16 have no effect on the byte.
- R7: valid_o is high for exactly one cycle per completed transfer. data_o changes only in a cycle where valid_o is high, and keeps its value otherwise.
- R8: req_i is ignored during a transfer. cs_no stays low, the frame still has 16 rising edges, and no new transfer starts if req_i is low when the frame ends.
- R9: MISO passes through SYNC_STAGES (2) flip-flops. The level captured is the one present at the sclk_o rising edge. A MISO change one clock after that edge, while sclk_o is still high, does not alter the byte.
- R10: valid_o goes high on the (SYNC_STAGES+1)-th clock edge after the edge on which sclk_o rises for data slot LEAD_BITS+DATA_BITS. This is the 3rd edge after rising edge 11 at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request to read one sample |
| miso_i | input | 1 | Serial data from the converter, asynchronous |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| data_o | output | DATA_BITS | Last captured sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The hardest situation to reach from the ports is one where a wrong sample point still yields the right byte. With a well-behaved converter model, MISO stays steady for a full serial clock period, so a strobe taken one or two clocks too early or too late goes unnoticed. To expose it, the converter model can invert MISO one system clock after each rising edge, which only a strobe aligned to the synchronizer delay survives. Other frames put ones in the pad slots, which catches a slot-count error. One frame holds the request high in the middle of the transfer and then checks that the transfer neither restarts nor changes length.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } ctrl_state_e;

  // system clocks per serial clock half period, never below one
  function automatic int half_count(input int clk_hz, input int sclk_hz);
    int h;
    h = clk_hz / (2 * sclk_hz);
    return (h < 1) ? 1 : h;
  endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int HALF_CNT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int CW = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      rise_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (!run_i) begin
        cnt_q  <= '0;
        sclk_q <= 1'b1;
      end else if (cnt_q == CW'(HALF_CNT - 1)) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
        rise_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = rise_q;

endmodule

// File: rtl/adc_miso_sync.sv
module adc_miso_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_spi_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rise_i,
  output logic run_o,
  output logic start_o,
  output logic cs_no
);
  localparam int RW = $clog2(FRAME_BITS + 1);

  ctrl_state_e   state_q;
  logic [RW-1:0] rise_cnt_q;
  logic          last_rise;

  assign last_rise = rise_i && (rise_cnt_q == RW'(FRAME_BITS - 1));
  // drop run in the cycle of the final rise so sclk parks high
  assign run_o     = (state_q == ST_XFER) && !last_rise;
  assign start_o   = (state_q == ST_IDLE) && req_i;
  assign cs_no     = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rise_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          rise_cnt_q <= '0;
          if (req_i) state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (rise_i) begin
            if (last_rise) state_q <= ST_IDLE;
            else           rise_cnt_q <= rise_cnt_q + RW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_sample_shift.sv
module adc_sample_shift #(
  parameter int DATA_BITS   = 8,
  parameter int LEAD_BITS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 rise_i,
  input  logic                 bit_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o
);
  localparam int LAST_SLOT = LEAD_BITS + DATA_BITS;
  localparam int SW        = $clog2(LAST_SLOT + 1);
  localparam int DLY       = SYNC_STAGES - 1;

  logic [DLY-1:0]       dly_q;
  logic                 tap;
  logic [SW-1:0]        slot_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 done_q;
  logic [DATA_BITS-1:0] data_q;
  logic                 valid_q;

  // align the strobe with the synchronizer output
  generate
    if (DLY == 1) begin : g_dly_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= rise_i;
      end
    end else begin : g_dly_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= {dly_q[DLY-2:0], rise_i};
      end
    end
  endgenerate

  assign tap = dly_q[DLY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      shreg_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        slot_q <= '0;
      end else if (tap && (slot_q < SW'(LAST_SLOT))) begin
        slot_q <= slot_q + SW'(1);
        if (slot_q >= SW'(LEAD_BITS)) shreg_q <= {shreg_q[DATA_BITS-2:0], bit_i};
        if (slot_q == SW'(LAST_SLOT - 1)) done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done_q;
      if (done_q) data_q <= shreg_q;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/adc_spi_reader.sv
module adc_spi_reader #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SCLK_HZ     = 4_000_000,
  parameter int FRAME_BITS  = 16,
  parameter int LEAD_BITS   = 3,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 miso_i,
  output logic                 cs_no,
  output logic                 sclk_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o
);
  localparam int HALF_CNT = adc_spi_pkg::half_count(CLK_HZ, SCLK_HZ);

  logic run;
  logic rise;
  logic start;
  logic miso_s;

  adc_frame_ctrl #(
    .FRAME_BITS(FRAME_BITS)
  ) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .rise_i (rise),
    .run_o  (run),
    .start_o(start),
    .cs_no  (cs_no)
  );

  adc_sclk_div #(
    .HALF_CNT(HALF_CNT)
  ) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .sclk_o(sclk_o),
    .rise_o(rise)
  );

  adc_miso_sync #(
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (miso_i),
    .q_o   (miso_s)
  );

  adc_sample_shift #(
    .DATA_BITS  (DATA_BITS),
    .LEAD_BITS  (LEAD_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .rise_i (rise),
    .bit_i  (miso_s),
    .data_o (data_o),
    .valid_o(valid_o)
  );

endmodule

// File: rtl/adc_spi_reader_chk.sv
module adc_spi_reader_chk #(
  parameter int FRAME_BITS = 16,
  parameter int HALF_CNT   = 12,
  parameter int DATA_BITS  = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 cs_no,
  input logic                 sclk_o,
  input logic [DATA_BITS-1:0] data_o,
  input logic                 valid_o
);
  localparam int RW = $clog2(FRAME_BITS + 1) + 1;
  localparam int LW = $clog2(HALF_CNT + 1) + 1;

  logic          sclk_prev;
  logic [RW-1:0] rise_seen;
  logic [LW-1:0] lvl_cnt;
  logic          seen_edge;
  logic          sclk_chg;

  assign sclk_chg = (sclk_o != sclk_prev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev <= 1'b1;
      rise_seen <= '0;
      lvl_cnt   <= '0;
      seen_edge <= 1'b0;
    end else begin
      sclk_prev <= sclk_o;
      if (cs_no) begin
        rise_seen <= '0;
        lvl_cnt   <= '0;
        seen_edge <= 1'b0;
      end else begin
        if (sclk_o && !sclk_prev) rise_seen <= rise_seen + RW'(1);
        if (sclk_chg) begin
          lvl_cnt   <= '0;
          seen_edge <= 1'b1;
        end else begin
          lvl_cnt <= lvl_cnt + LW'(1);
        end
      end
    end
  end

  // R2
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  // R3
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && req_i) |=> !cs_no);

  // R5
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (rise_seen == RW'(FRAME_BITS)));

  // R4
  half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_chg && seen_edge) |-> (lvl_cnt == LW'(HALF_CNT - 1)));

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

endmodule

bind adc_spi_reader adc_spi_reader_chk #(
  .FRAME_BITS(FRAME_BITS),
  .HALF_CNT  (HALF_CNT),
  .DATA_BITS (DATA_BITS)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .cs_no  (cs_no),
  .sclk_o (sclk_o),
  .data_o (data_o),
  .valid_o(valid_o)
);

// File: tb/test_adc_spi_reader.sv
`timescale 1ns/1ps
module test_adc_spi_reader;
  localparam int HALF  = 12;
  localparam int FRAME = 16;
  localparam int LEAD  = 3;
  localparam int DBITS = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       req_i;
  logic       miso_i;
  logic       cs_no;
  logic       sclk_o;
  logic [7:0] data_o;
  logic       valid_o;

  int errors = 0;
  int checks = 0;

  logic [15:0] tx_word;
  int          slot;
  bit          glitch_en;

  always #5 clk_i = ~clk_i;

  adc_spi_reader i_adc_spi_reader (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .miso_i (miso_i),
    .cs_no  (cs_no),
    .sclk_o (sclk_o),
    .data_o (data_o),
    .valid_o(valid_o)
  );

  // converter model: next bit on each falling sclk edge
  initial begin
    miso_i = 1'b0;
    slot   = 0;
    forever begin
      @(negedge sclk_o);
      if (!cs_no && slot < FRAME) begin
        slot++;
        miso_i = tx_word[FRAME-slot];
      end
    end
  end

  // disturbance: flip MISO one clock after each rising edge
  initial begin
    forever begin
      @(posedge sclk_o);
      if (glitch_en && !cs_no) begin
        @(posedge clk_i);
        #1 miso_i = ~miso_i;
      end
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic test_reset_idle();
    rst_ni = 1'b0; req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", "cs_no in reset", cs_no, 1);
    chk("R1", "sclk_o in reset", sclk_o, 1);
    chk("R1", "valid_o in reset", valid_o, 0);
    chk("R1", "data_o in reset", data_o, 0);
    rst_ni = 1'b1;
    begin
      int bad = 0;
      repeat (40) begin
        @(negedge clk_i);
        if (!cs_no || !sclk_o) bad++;
      end
      chk("R2", "idle cycles with cs or sclk low", bad, 0);
    end
  endtask

  task automatic run_frame(input logic [7:0] val, input bit pad_ones, input bit glitch,
                           input bit mid_req, input string tag);
    int rises = 0, lvl = 1, n = 0, valid_cnt = 0;
    int t_valid = -1, t_data = -1, t_end = -1, bad_lvl = 0, post_bad = 0;
    logic prev;
    logic [7:0] got = 8'h00;
    tx_word   = pad_ones ? {3'b111, val, 5'b11111} : {3'b000, val, 5'b00000};
    glitch_en = glitch;
    slot      = 0;
    miso_i    = 1'b0;
    @(negedge clk_i); req_i = 1'b1;
    @(negedge clk_i); req_i = 1'b0;
    chk("R3", {tag, " cs_no after request"}, cs_no, 0);
    prev = sclk_o;
    while (n < 2000) begin
      @(negedge clk_i); n++;
      if (mid_req) req_i = (rises >= 5 && rises < 8);
      if (valid_o) begin valid_cnt++; got = data_o; t_valid = n; end
      if (cs_no) break;
      if (sclk_o != prev) begin
        if (lvl != HALF) bad_lvl++;
        lvl = 1;
        if (sclk_o) begin
          rises++;
          if (rises == LEAD + DBITS) t_data = n;
          if (rises == FRAME) t_end = n;
        end
      end else begin
        lvl++;
      end
      prev = sclk_o;
    end
    req_i = 1'b0;
    chk("R4", {tag, " sclk levels of wrong length"}, bad_lvl, 0);
    chk("R5", {tag, " rising edges per frame"}, rises, FRAME);
    chk("R5", {tag, " cs rise delay after last edge"}, n - t_end, 1);
    chk("R10", {tag, " valid delay after last data edge"}, t_valid - t_data, 3);
    repeat (4) begin
      @(negedge clk_i);
      if (valid_o) valid_cnt++;
      if (!cs_no || !sclk_o) post_bad++;
    end
    chk("R7", {tag, " valid pulses"}, valid_cnt, 1);
    chk(glitch ? "R9" : (pad_ones ? "R6" : "R6"), {tag, " byte"}, got, val);
    chk("R7", {tag, " data held after strobe"}, data_o, val);
    chk(mid_req ? "R8" : "R2", {tag, " lines after frame"}, post_bad, 0);
    glitch_en = 1'b0;
  endtask

  task automatic test_reset_mid();
    tx_word = 16'h1FE0;
    slot = 0;
    @(negedge clk_i); req_i = 1'b1;
    @(negedge clk_i); req_i = 1'b0;
    repeat (100) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", "cs_no on mid-frame reset", cs_no, 1);
    chk("R1", "sclk_o on mid-frame reset", sclk_o, 1);
    chk("R1", "valid_o on mid-frame reset", valid_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R1", "no transfer after reset", cs_no, 1);
  endtask

  initial begin
    req_i = 1'b0;
    glitch_en = 1'b0;
    tx_word = '0;
    test_reset_idle();
    run_frame(8'hA5, 1'b0, 1'b0, 1'b0, "basic");
    run_frame(8'h00, 1'b1, 1'b0, 1'b0, "pad_ones_zero");
    run_frame(8'hFF, 1'b0, 1'b0, 1'b0, "all_ones");
    run_frame(8'h81, 1'b1, 1'b0, 1'b0, "pad_ones_ends");
    run_frame(8'h3C, 1'b0, 1'b1, 1'b0, "glitch");
    run_frame(8'hC3, 1'b1, 1'b1, 1'b0, "glitch_pad");
    run_frame(8'h96, 1'b0, 1'b0, 1'b1, "mid_request");
    test_reset_mid();
    run_frame(8'h5A, 1'b0, 1'b0, 1'b0, "after_reset");
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

endmodule